// File: doc/BRIEF.md
# Timer Interrupt Status Router

This block sits behind a bank of timer channels. Each channel signals expiry with a one-cycle fire strobe, and the block turns those strobes into interrupt lines plus a shared status word. A channel set to level type latches its status bit and holds its line asserted until software clears the bit through the status write port. A channel set to edge type leaves its status bit clear and gives a single-cycle pulse on its line. Each channel picks its line with a route field. Lines numbered at or above `LOW_BASE` are active-low; all lower lines are active-high.

A legacy takeover mode hands two fixed lines to channels 0 and 1, whatever their route fields say. Outside that mode, the same two lines carry two external sources, an interval-timer input and a clock input. The mode is held by a two-state controller. `LM_NORMAL` moves to `LM_LEGACY` on the TAKEOVER transition, when `legacy_mode` is sampled high. `LM_LEGACY` returns to `LM_NORMAL` on the RELEASE transition, when it is sampled low. In all other cycles each state holds. In `LM_NORMAL` the interval-timer enable output is high. In `LM_LEGACY` it is low and both external sources are kept off their lines.

All state is registered. A stimulus sampled at a rising clock edge shows up at the outputs right after that edge.

Top module: `irq_status_router`

## Requirements
- R1: While the controller is in `LM_LEGACY`, channel 0 drives line `LEG_LINE_A` (default 0) and channel 1 drives line `LEG_LINE_B` (default 8), and their route fields are ignored. All other channels keep using their route field.
- R2: Outside legacy mode, channel c drives the line whose index equals `ch_route[c*RW +: RW]`, where `RW = $clog2(N_LINES)`. A route value of `N_LINES` or more drives no line.
- R3: If an enabled level-type channel (`ch_level[c]=1`) fires while `glb_en` is high, `status[c]` is set after that edge. The channel's line stays asserted until the bit is cleared.
- R4: If an enabled edge-type channel (`ch_level[c]=0`) fires, `status[c]` is left unchanged and the channel's line is asserted for exactly one cycle after that edge.
- R5: A line with index at or above `LOW_BASE` (default 16) idles at 1 and is asserted by driving 0. Lower lines idle at 0 and are asserted by driving 1.
- R6: If `status_wr` is high, each bit set in `status_wdata` clears the matching status bit and deasserts that channel's line after the edge. A level fire in the same cycle takes priority and keeps the bit set.
- R7: If `ch_en[c]` or `glb_en` is low at an edge, `status[c]` is cleared, any pulse is cancelled and the channel drives nothing after that edge. A fire in that cycle is ignored.
- R8: On TAKEOVER, `pit_enable` goes low, and lines `LEG_LINE_A` and `LEG_LINE_B` stop carrying the external sources.
- R9: On RELEASE, `pit_enable` goes high and line `LEG_LINE_B` again follows the most recently recorded level of `rtc_in`.
- R10: In `LM_NORMAL`, line `LEG_LINE_A` carries `pit_in` and line `LEG_LINE_B` carries `rtc_in`, each one register stage late and combined by OR with any channel routed there. The `rtc_in` level is recorded in every state.
- R11: After reset, every status bit is 0, every line sits at its idle level, the recorded clock level is 0, and `pit_enable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fire | input | N_CH | Per-channel expiry strobe |
| ch_en | input | N_CH | Per-channel enable |
| ch_level | input | N_CH | 1 = level type, 0 = edge type |
| ch_route | input | N_CH*RW | Packed route fields; channel c uses bits [c*RW +: RW] |
| glb_en | input | 1 | Global enable |
| legacy_mode | input | 1 | Legacy takeover request |
| pit_in | input | 1 | External interval-timer interrupt source |
| rtc_in | input | 1 | External clock interrupt source |
| status_wr | input | 1 | Status write strobe |
| status_wdata | input | N_CH | Write-one-to-clear mask |
| irq_lines | output | N_LINES | Interrupt lines, with polarity applied per line |
| status | output | N_CH | Shared status word |
| pit_enable | output | 1 | Interval-timer enable, low in legacy mode |

## Verification
The bench aims at a legacy switch made while the external inputs are high. A router that failed to drop them on TAKEOVER would leave line 0 or 8 stuck high. One that did not record the clock input while in legacy mode would bring line 8 back stale on RELEASE. It also drives routes into the active-low range and past the last line. A polarity error shows up as an idle line reading 0, and a missing bounds check shows up as a stray assertion on some other line. Finally, the bench lines up clears against same-cycle fires, switches channels off while they hold status, and sends single edge fires. Wrong priority, leftover status or a pulse that lasts two cycles each shows up as a mismatch with the bench model.

// File: rtl/tisr_pkg.sv
package tisr_pkg;
    typedef enum logic {
        LM_NORMAL = 1'b0,
        LM_LEGACY = 1'b1
    } leg_state_e;
endpackage

// File: rtl/tisr_chan.sv
module tisr_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic en,
    input  logic level,
    input  logic clr,
    output logic status_q,
    output logic pulse_q,
    output logic active
);
    logic set_lvl;
    logic set_edge;

    always_comb begin
        set_lvl  = fire && level;
        set_edge = fire && !level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else if (!en) begin
            status_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            status_q <= (status_q && !clr) || set_lvl;
            pulse_q  <= set_edge;
        end
    end

    assign active = status_q || pulse_q;

    // R3
    level_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && en && level) |=> status_q);

    // R4
    edge_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && en && !level && !status_q) |=> !status_q);

    // R6
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(fire && level)) |=> !status_q);

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !active);
endmodule

// File: rtl/tisr_legacy_ctl.sv
module tisr_legacy_ctl
    import tisr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic legacy_req,
    input  logic pit_src,
    input  logic rtc_src,
    output logic in_legacy,
    output logic pit_enable,
    output logic ext_a,
    output logic ext_b
);
    leg_state_e state_q;
    leg_state_e state_d;
    logic       pit_q;
    logic       rtc_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LM_NORMAL: if (legacy_req)  state_d = LM_LEGACY;  // TAKEOVER
            LM_LEGACY: if (!legacy_req) state_d = LM_NORMAL;  // RELEASE
            default:                    state_d = LM_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LM_NORMAL;
            pit_q   <= 1'b0;
            rtc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pit_q   <= pit_src;
            rtc_q   <= rtc_src;
        end
    end

    always_comb begin
        in_legacy  = 1'b0;
        pit_enable = 1'b1;
        ext_a      = 1'b0;
        ext_b      = 1'b0;
        unique case (state_q)
            LM_NORMAL: begin
                ext_a = pit_q;
                ext_b = rtc_q;
            end
            LM_LEGACY: begin
                in_legacy  = 1'b1;
                pit_enable = 1'b0;
            end
            default: ;
        endcase
    end

    // R8
    takeover_pit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(legacy_req) |=> (!pit_enable && !ext_a && !ext_b));

    // R9
    release_rtc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(legacy_req) |=> (pit_enable && (ext_b == $past(rtc_src))));

    // R10
    normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_req) |=> (ext_a == $past(pit_src)));
endmodule

// File: rtl/tisr_line_map.sv
module tisr_line_map #(
    parameter int N_CH       = 4,
    parameter int N_LINES    = 24,
    parameter int LOW_BASE   = 16,
    parameter int LEG_LINE_A = 0,
    parameter int LEG_LINE_B = 8,
    localparam int RW        = $clog2(N_LINES)
) (
    input  logic [N_CH-1:0]    active,
    input  logic [N_CH*RW-1:0] routes,
    input  logic               in_legacy,
    input  logic               ext_a,
    input  logic               ext_b,
    output logic [N_LINES-1:0] lines
);
    logic [RW-1:0]      eff [N_CH];
    logic [N_LINES-1:0] asrt;

    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            if (in_legacy && c == 0)      eff[c] = RW'(LEG_LINE_A);
            else if (in_legacy && c == 1) eff[c] = RW'(LEG_LINE_B);
            else                          eff[c] = routes[c*RW +: RW];
        end
    end

    always_comb begin
        asrt = '0;
        for (int l = 0; l < N_LINES; l++) begin
            for (int c = 0; c < N_CH; c++) begin
                if (32'(eff[c]) == l && active[c]) asrt[l] = 1'b1;
            end
        end
        asrt[LEG_LINE_A] = asrt[LEG_LINE_A] | ext_a;
        asrt[LEG_LINE_B] = asrt[LEG_LINE_B] | ext_b;
    end

    for (genvar l = 0; l < N_LINES; l++) begin : g_pol
        if (l >= LOW_BASE) begin : g_low
            assign lines[l] = ~asrt[l];
        end else begin : g_high
            assign lines[l] = asrt[l];
        end
    end
endmodule

// File: rtl/irq_status_router.sv
module irq_status_router #(
    parameter int N_CH       = 4,
    parameter int N_LINES    = 24,
    parameter int LOW_BASE   = 16,
    parameter int LEG_LINE_A = 0,
    parameter int LEG_LINE_B = 8,
    localparam int RW        = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CH-1:0]    fire,
    input  logic [N_CH-1:0]    ch_en,
    input  logic [N_CH-1:0]    ch_level,
    input  logic [N_CH*RW-1:0] ch_route,
    input  logic               glb_en,
    input  logic               legacy_mode,
    input  logic               pit_in,
    input  logic               rtc_in,
    input  logic               status_wr,
    input  logic [N_CH-1:0]    status_wdata,
    output logic [N_LINES-1:0] irq_lines,
    output logic [N_CH-1:0]    status,
    output logic               pit_enable
);
    logic [N_CH-1:0] active;
    logic [N_CH-1:0] pulse;
    logic            in_legacy;
    logic            ext_a;
    logic            ext_b;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        tisr_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .fire     (fire[c]),
            .en       (ch_en[c] && glb_en),
            .level    (ch_level[c]),
            .clr      (status_wr && status_wdata[c]),
            .status_q (status[c]),
            .pulse_q  (pulse[c]),
            .active   (active[c])
        );
    end

    tisr_legacy_ctl u_leg (
        .clk        (clk),
        .rst_n      (rst_n),
        .legacy_req (legacy_mode),
        .pit_src    (pit_in),
        .rtc_src    (rtc_in),
        .in_legacy  (in_legacy),
        .pit_enable (pit_enable),
        .ext_a      (ext_a),
        .ext_b      (ext_b)
    );

    tisr_line_map #(
        .N_CH       (N_CH),
        .N_LINES    (N_LINES),
        .LOW_BASE   (LOW_BASE),
        .LEG_LINE_A (LEG_LINE_A),
        .LEG_LINE_B (LEG_LINE_B)
    ) u_map (
        .active    (active),
        .routes    (ch_route),
        .in_legacy (in_legacy),
        .ext_a     (ext_a),
        .ext_b     (ext_b),
        .lines     (irq_lines)
    );

    // R1
    legacy_ch0_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_legacy && status[0]) |-> irq_lines[LEG_LINE_A]);

    // R1
    legacy_ch1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_legacy && status[1]) |-> irq_lines[LEG_LINE_B]);

    for (genvar l = LOW_BASE; l < N_LINES; l++) begin : g_idle_chk
        // R5
        low_line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !glb_en |=> irq_lines[l]);
    end
endmodule

// File: tb/tb_irq_status_router.sv
module tb_irq_status_router;
    localparam int CLK_PERIOD = 10;
    localparam int N_CH = 4;
    localparam int N_LINES = 24;
    localparam int LOW_BASE = 16;
    localparam int RW = $clog2(N_LINES);
    localparam int LA = 0;
    localparam int LB = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic [N_CH-1:0] fire = '0, ch_en = '0, ch_level = '0, status_wdata = '0;
    logic [N_CH*RW-1:0] ch_route = '0;
    logic glb_en = 0, legacy_mode = 0, pit_in = 0, rtc_in = 0, status_wr = 0;
    logic [N_LINES-1:0] irq_lines;
    logic [N_CH-1:0] status;
    logic pit_enable;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_router dut (
        .clk(clk), .rst_n(rst_n), .fire(fire), .ch_en(ch_en), .ch_level(ch_level),
        .ch_route(ch_route), .glb_en(glb_en), .legacy_mode(legacy_mode),
        .pit_in(pit_in), .rtc_in(rtc_in), .status_wr(status_wr),
        .status_wdata(status_wdata), .irq_lines(irq_lines), .status(status),
        .pit_enable(pit_enable)
    );

    // Reference model built from the requirements
    logic [N_CH-1:0] m_st, m_pl;
    logic m_leg, m_pit, m_rtc;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= '0; m_pl <= '0; m_leg <= 0; m_pit <= 0; m_rtc <= 0;
        end else begin
            for (int c = 0; c < N_CH; c++) begin
                if (!(ch_en[c] && glb_en)) begin
                    m_st[c] <= 0; m_pl[c] <= 0;
                end else begin
                    m_st[c] <= (m_st[c] && !(status_wr && status_wdata[c])) || (fire[c] && ch_level[c]);
                    m_pl[c] <= fire[c] && !ch_level[c];
                end
            end
            m_leg <= legacy_mode; m_pit <= pit_in; m_rtc <= rtc_in;
        end
    end

    function automatic logic [N_LINES-1:0] exp_lines();
        logic [N_LINES-1:0] a = '0;
        for (int c = 0; c < N_CH; c++) begin
            int r = int'(ch_route[c*RW +: RW]);
            if (m_leg && c == 0) r = LA;
            if (m_leg && c == 1) r = LB;
            if (r < N_LINES && (m_st[c] || m_pl[c])) a[r] = 1'b1;
        end
        if (!m_leg) begin
            a[LA] = a[LA] | m_pit;
            a[LB] = a[LB] | m_rtc;
        end
        for (int l = LOW_BASE; l < N_LINES; l++) a[l] = ~a[l];
        return a;
    endfunction

    task automatic compare(string tag);
        logic [N_LINES-1:0] el = exp_lines();
        checks++;
        if (irq_lines !== el) begin
            errors++;
            $display("FAIL %s lines actual=%h expected=%h", tag, irq_lines, el);
        end
        checks++;
        if (status !== m_st) begin
            errors++;
            $display("FAIL %s status actual=%h expected=%h", tag, status, m_st);
        end
        checks++;
        if (pit_enable !== !m_leg) begin
            errors++;
            $display("FAIL %s pit_enable actual=%b expected=%b", tag, pit_enable, !m_leg);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic set_route(int c, int r);
        ch_route[c*RW +: RW] = RW'(r);
    endtask

    task automatic expect_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        compare("R11 reset");
        expect_bit("R11 reset idle low line", irq_lines[20], 1'b1);
        rst_n = 1;
        ch_en = '1; glb_en = 1;
        for (int c = 0; c < N_CH; c++) set_route(c, 1 + c);
        tick("R11 after reset");

        // R3 + R5: level channel 2 to active-low line 20
        set_route(2, 20); ch_level[2] = 1; fire[2] = 1;
        tick("R3 level set");
        fire[2] = 0;
        expect_bit("R5 line 20 driven low", irq_lines[20], 1'b0);
        tick("R3 level hold");
        // R6: clear, and clear losing against a same-cycle fire
        status_wr = 1; status_wdata = 4'b0100; fire[2] = 1;
        tick("R6 fire beats clear");
        fire[2] = 0;
        tick("R6 clear");
        status_wr = 0; status_wdata = '0;
        expect_bit("R6 line 20 idle", irq_lines[20], 1'b1);
        tick("R6 stays clear");

        // R4: edge channel 3 on line 5
        set_route(3, 5); ch_level[3] = 0; fire[3] = 1;
        tick("R4 pulse");
        fire[3] = 0;
        expect_bit("R4 pulse high", irq_lines[5], 1'b1);
        tick("R4 pulse over");
        expect_bit("R4 one cycle", irq_lines[5], 1'b0);

        // R10: external pass-through, then R8 takeover
        pit_in = 1; rtc_in = 1;
        tick("R10 sample");
        tick("R10 passthrough");
        expect_bit("R10 line 0", irq_lines[LA], 1'b1);
        legacy_mode = 1;
        tick("R8 takeover");
        expect_bit("R8 line 8 dropped", irq_lines[LB], 1'b0);
        // R1: channels 0 and 1 routed elsewhere but forced to 0 and 8
        set_route(0, 12); set_route(1, 13); ch_level[1:0] = 2'b11; fire[1:0] = 2'b11;
        tick("R1 legacy routing");
        fire = '0;
        expect_bit("R1 line 8 from ch1", irq_lines[LB], 1'b1);
        status_wr = 1; status_wdata = 4'b0011;
        tick("R1 clear");
        status_wr = 0; status_wdata = '0;
        rtc_in = 0;
        tick("R10 recorded in legacy");
        rtc_in = 1;
        legacy_mode = 0;
        tick("R9 release");
        expect_bit("R9 line 8 follows clock", irq_lines[LB], 1'b1);

        // R7: enable off while holding status
        fire[2] = 1; ch_level[2] = 1;
        tick("R7 prep");
        fire[2] = 1; glb_en = 0;
        tick("R7 global off");
        fire[2] = 0; glb_en = 1; ch_en[2] = 0; fire[2] = 1;
        tick("R7 channel off");
        fire[2] = 0; ch_en[2] = 1;

        // R2: out-of-range route
        set_route(3, 30); ch_level[3] = 1; fire[3] = 1;
        tick("R2 invalid route");
        fire[3] = 0;
        pit_in = 0; rtc_in = 0;
        tick("R2 invalid route idle");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            fire = N_CH'($urandom);
            if ($urandom_range(0, 15) == 0) ch_level = N_CH'($urandom);
            if ($urandom_range(0, 31) == 0) ch_route = (N_CH*RW)'({$urandom, $urandom});
            ch_en = ($urandom_range(0, 19) == 0) ? N_CH'($urandom) : '1;
            glb_en = ($urandom_range(0, 49) != 0);
            if ($urandom_range(0, 63) == 0) legacy_mode = !legacy_mode;
            pit_in = $urandom_range(0, 1) == 1;
            rtc_in = $urandom_range(0, 1) == 1;
            status_wr = $urandom_range(0, 3) == 0;
            status_wdata = N_CH'($urandom);
            tick("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
        end
        finish_run();
    end
endmodule